// File: doc/BRIEF.md
# Three-Share Masked 4-bit S-box

This block evaluates the 4-bit substitution box of a lightweight block cipher on data that is never present in plain form. The caller splits each nibble into three Boolean shares whose XOR is the true value. The block returns three output shares whose XOR is the S-box image of that value. The cubic S-box is computed as two quadratic bijections, G first and then F. Each of them is split into three component functions, and every component function reads only two of the three shares. A register between the two stages keeps glitches in the G logic from reaching the F logic, and a second register captures the result.

A plain direct sharing of G is not uniform. A leak-free first-order masking needs uniform shares, so G's bit 1 carries correction terms. Each product term c·b of one share is XORed into the two component functions that can see it, so the terms cancel in the sum and the output sharing becomes uniform. The correction is the last XOR on that bit. The block makes no randomness of its own.

Data moves on a valid/ready stream. One global advance condition moves both registers together: the pipeline advances when the output slot is empty or the consumer accepts. `in_ready` follows that condition in the same cycle. A result stays on the output until the consumer takes it, and an input offered while `in_ready` is low is not taken. The sharing logic uses the nibble bit order (d,c,b,a) = bits 3..0.

Top module: `ti_sbox3`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both pipeline stages. In the first cycle after reset `out_valid` is 0, all three output shares are 0 and `in_ready` is 1.
- R2: For every accepted input, out_sh0^out_sh1^out_sh2 equals S(in_sh0^in_sh1^in_sh2). S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 and is the composition of G (0..F to 7,E,9,2,B,0,4,D,5,C,A,1,8,3,6,F) followed by F (0..F to 0,8,B,7,A,3,1,C,4,6,F,9,E,D,5,2). One clock after acceptance, the XOR of the stored intermediate shares equals G of the input value.
- R3: If the consumer is ready, an input accepted at clock edge k is on the output with `out_valid` high after edge k+1, and not before.
- R4: Across all 4096 input share triples, the 12-bit output share triples {out_sh2,out_sh1,out_sh0} are pairwise distinct. So for each plain value, each of the 256 sharings of its image appears exactly once.
- R5: While `out_valid` is 1 and `out_ready` is 0, the output shares and `out_valid` hold their values at the next edge.
- R6: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0. Data offered while `in_ready` is 0 is never delivered.
- R7: With `out_ready` held high, back-to-back inputs give one result per cycle, in input order.
- R8: A cycle with `in_valid` low puts an empty slot in the pipeline, so `out_valid` is 0 two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input shares are offered |
| in_ready | output | 1 | Block takes the offered shares at this edge |
| in_sh0 | input | 4 | Input share 0, bits (d,c,b,a) = 3..0 |
| in_sh1 | input | 4 | Input share 1 |
| in_sh2 | input | 4 | Input share 2 |
| out_valid | output | 1 | Output shares hold a result |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_sh0 | output | 4 | Output share 0 |
| out_sh1 | output | 4 | Output share 1 |
| out_sh2 | output | 4 | Output share 2 |

## Verification
A wrong G or F component term, or a wrong constant, changes the XOR of the output shares two cycles after the affected input is accepted. A dropped or misplaced correction term leaves that XOR correct, so it is visible only as a repeated output sharing once the full 4096-triple sweep ends. A wrong advance or hold condition shows up within one cycle of a stall as a changed output, a lost or repeated result, or a result arriving one slot out of order.

// File: rtl/ti_pkg.sv
`timescale 1ns/1ps
package ti_pkg;
  localparam int NIB = 4;
  localparam int NSH = 3;

  typedef logic [NIB-1:0] nib_t;
  typedef nib_t [NSH-1:0] shares_t;

  // unshared first quadratic stage, used only by the checker
  function automatic nib_t g_ref(input nib_t x);
    case (x)
      4'h0: g_ref = 4'h7; 4'h1: g_ref = 4'hE; 4'h2: g_ref = 4'h9; 4'h3: g_ref = 4'h2;
      4'h4: g_ref = 4'hB; 4'h5: g_ref = 4'h0; 4'h6: g_ref = 4'h4; 4'h7: g_ref = 4'hD;
      4'h8: g_ref = 4'h5; 4'h9: g_ref = 4'hC; 4'hA: g_ref = 4'hA; 4'hB: g_ref = 4'h1;
      4'hC: g_ref = 4'h8; 4'hD: g_ref = 4'h3; 4'hE: g_ref = 4'h6; default: g_ref = 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/ti_g_comp.sv
`timescale 1ns/1ps
// One component of the shared G map. It sees the share that follows its
// own index (own) and the one after that (oth), never its own share.
module ti_g_comp
  import ti_pkg::*;
#(
  parameter int IDX = 0
) (
  input  nib_t own,
  input  nib_t oth,
  output nib_t y
);
  localparam logic KONE = (IDX == 0) ? 1'b1 : 1'b0;

  logic ap, bp, cp, dp, aq, bq, cq, dq;
  logic core1, fix1;

  assign {dp, cp, bp, ap} = own;
  assign {dq, cq, bq, aq} = oth;

  assign y[0] = KONE ^ ap
              ^ (dp & cq) ^ (dq & cp) ^ (dp & bq) ^ (dq & bp) ^ (cp & bq) ^ (cq & bp)
              ^ (dp & cp) ^ (dp & bp) ^ (cp & bp);

  assign core1 = KONE ^ bp ^ dq
               ^ (cp & aq) ^ (cq & ap) ^ (bp & aq) ^ (bq & ap)
               ^ (cp & ap) ^ (bp & ap);

  // uniformity correction: each c*b product of one share goes into two components
  assign fix1 = (cp & bp) ^ (cq & bq);
  assign y[1] = core1 ^ fix1;

  assign y[2] = KONE ^ cp ^ bp;
  assign y[3] = cp ^ bp ^ ap;
endmodule

// File: rtl/ti_f_comp.sv
`timescale 1ns/1ps
// One component of the shared F map, same share rotation as the G side.
module ti_f_comp
  import ti_pkg::*;
(
  input  nib_t own,
  input  nib_t oth,
  output nib_t y
);
  logic ap, bp, cp, dp, aq, bq, cq, dq;
  logic da_x;

  assign {dp, cp, bp, ap} = own;
  assign {dq, cq, bq, aq} = oth;

  assign da_x = (dp & ap) ^ (dp & aq) ^ (dq & ap);

  assign y[0] = bp ^ (cp & ap) ^ (cp & aq) ^ (cq & ap);
  assign y[1] = cp ^ bp ^ da_x;
  assign y[2] = dp ^ (bp & ap) ^ (bp & aq) ^ (bq & ap);
  assign y[3] = cp ^ bp ^ ap ^ da_x;
endmodule

// File: rtl/ti_stage.sv
`timescale 1ns/1ps
// Pipeline slot: payload plus valid flag, loaded when the pipeline advances.
module ti_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (en) begin
      vout <= vin;
      dout <= din;
    end
  end
endmodule

// File: rtl/ti_sbox3.sv
`timescale 1ns/1ps
module ti_sbox3
  import ti_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NIB-1:0] in_sh0,
  input  logic [NIB-1:0] in_sh1,
  input  logic [NIB-1:0] in_sh2,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [NIB-1:0] out_sh0,
  output logic [NIB-1:0] out_sh1,
  output logic [NIB-1:0] out_sh2
);
  localparam int SW = NSH * NIB;

  logic    adv;
  shares_t in_sh, g_sh, st1_sh, f_sh, o_sh;
  logic    st1_vld;

  // one advance condition for the whole pipe: output slot free or being drained
  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  assign in_sh[0] = in_sh0;
  assign in_sh[1] = in_sh1;
  assign in_sh[2] = in_sh2;

  for (genvar i = 0; i < NSH; i++) begin : g_gcomp
    ti_g_comp #(.IDX(i)) u_g (
      .own (in_sh[(i + 1) % NSH]),
      .oth (in_sh[(i + 2) % NSH]),
      .y   (g_sh[i])
    );
  end

  ti_stage #(.W(SW)) u_st1 (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .vin  (in_valid),
    .din  (g_sh),
    .vout (st1_vld),
    .dout (st1_sh)
  );

  for (genvar i = 0; i < NSH; i++) begin : g_fcomp
    ti_f_comp u_f (
      .own (st1_sh[(i + 1) % NSH]),
      .oth (st1_sh[(i + 2) % NSH]),
      .y   (f_sh[i])
    );
  end

  ti_stage #(.W(SW)) u_st2 (
    .clk  (clk),
    .rst  (rst),
    .en   (adv),
    .vin  (st1_vld),
    .din  (f_sh),
    .vout (out_valid),
    .dout (o_sh)
  );

  assign out_sh0 = o_sh[0];
  assign out_sh1 = o_sh[1];
  assign out_sh2 = o_sh[2];
endmodule

// File: rtl/ti_sbox3_chk.sv
`timescale 1ns/1ps
module ti_sbox3_chk
  import ti_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    in_valid,
  input logic    in_ready,
  input nib_t    in_sh0,
  input nib_t    in_sh1,
  input nib_t    in_sh2,
  input logic    out_valid,
  input logic    out_ready,
  input nib_t    out_sh0,
  input nib_t    out_sh1,
  input nib_t    out_sh2,
  input shares_t st1_sh
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready && out_sh0 == '0 && out_sh1 == '0 && out_sh2 == '0));

  // R2
  g_stage_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      ((st1_sh[0] ^ st1_sh[1] ^ st1_sh[2]) == g_ref($past(in_sh0 ^ in_sh1 ^ in_sh2))));

  // R3
  two_cycle_lat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready, 2) && $past(out_ready) && !$past(rst) && !$past(rst, 2))
      |-> out_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_sh2, out_sh1, out_sh0})));
endmodule

bind ti_sbox3 ti_sbox3_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sh0    (in_sh0),
  .in_sh1    (in_sh1),
  .in_sh2    (in_sh2),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sh0   (out_sh0),
  .out_sh1   (out_sh1),
  .out_sh2   (out_sh2),
  .st1_sh    (st1_sh)
);

// File: tb/sim_ti_sbox3.sv
`timescale 1ns/1ps
module sim_ti_sbox3;
  localparam logic [3:0] SBOX [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                       4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [3:0] in_sh0, in_sh1, in_sh2, out_sh0, out_sh1, out_sh2;

  always #2.5 clk = ~clk;

  ti_sbox3 u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sh0    (in_sh0),
    .in_sh1    (in_sh1),
    .in_sh2    (in_sh2),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sh0   (out_sh0),
    .out_sh1   (out_sh1),
    .out_sh2   (out_sh2)
  );

  int n_run = 0;
  int n_bad = 0;
  bit seen [4096];

  task automatic expect_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] out_x();
    return out_sh0 ^ out_sh1 ^ out_sh2;
  endfunction

  // offer a plain value x, masked by two chosen shares
  task automatic offer(input logic v, input logic [3:0] x, input logic [3:0] m1, input logic [3:0] m2);
    in_valid = v;
    in_sh1   = m1;
    in_sh2   = m2;
    in_sh0   = x ^ m1 ^ m2;
  endtask

  initial begin
    #(5.0 * 200000);
    n_run++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int dup;
    rst = 1'b1;
    out_ready = 1'b1;
    offer(1'b0, 4'h0, 4'h0, 4'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state straight out of reset
    expect_eq("R1 out_valid after reset", int'(out_valid), 0);
    expect_eq("R1 shares after reset", int'({out_sh2, out_sh1, out_sh0}), 0);
    expect_eq("R1 in_ready after reset", int'(in_ready), 1);

    // R2 R3 R4: every share triple, one at a time
    dup = 0;
    for (int idx = 0; idx < 4096; idx++) begin
      logic [11:0] v;
      v = idx[11:0];
      in_valid = 1'b1;
      in_sh0 = v[3:0];
      in_sh1 = v[7:4];
      in_sh2 = v[11:8];
      @(negedge clk);
      in_valid = 1'b0;
      expect_eq("R3 no result after one edge", int'(out_valid), 0);
      @(negedge clk);
      expect_eq("R3 result after two edges", int'(out_valid), 1);
      expect_eq("R2 unmasked image", int'(out_x()), int'(SBOX[v[3:0] ^ v[7:4] ^ v[11:8]]));
      if (seen[{out_sh2, out_sh1, out_sh0}]) dup++;
      seen[{out_sh2, out_sh1, out_sh0}] = 1'b1;
    end
    expect_eq("R4 repeated output sharings", dup, 0);

    // R7 R8: back-to-back stream with one empty slot at position 5
    for (int t = 0; t < 18; t++) begin
      if (t >= 2) begin
        int j;
        j = t - 2;
        if (j == 5) begin
          expect_eq("R8 empty slot", int'(out_valid), 0);
        end else begin
          expect_eq("R7 stream valid", int'(out_valid), 1);
          expect_eq("R7 stream order", int'(out_x()), int'(SBOX[j[3:0]]));
        end
      end
      if (t < 16) begin
        logic [3:0] x;
        x = t[3:0];
        offer(t != 5, x, x * 4'd7 + 4'd3, x * 4'd11 + 4'd1);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // R5 R6: back-pressure
    out_ready = 1'b0;
    offer(1'b1, 4'h3, 4'hA, 4'h5);
    @(negedge clk);
    offer(1'b1, 4'h9, 4'h2, 4'hF);
    @(negedge clk);
    expect_eq("R6 in_ready low while stalled", int'(in_ready), 0);
    offer(1'b1, 4'hE, 4'h6, 4'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_eq("R5 held valid", int'(out_valid), 1);
      expect_eq("R5 held result", int'(out_x()), int'(SBOX[4'h3]));
      expect_eq("R6 in_ready still low", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    expect_eq("R6 second result after release", int'(out_x()), int'(SBOX[4'h9]));
    expect_eq("R6 second result valid", int'(out_valid), 1);
    @(negedge clk);
    expect_eq("R6 stalled offer not taken", int'(out_valid), 0);

    // R1: reset with data in flight
    offer(1'b1, 4'h7, 4'h4, 4'hB);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_eq("R1 flush valid", int'(out_valid), 0);
    expect_eq("R1 flush shares", int'({out_sh2, out_sh1, out_sh0}), 0);
    @(negedge clk);
    expect_eq("R1 nothing emerges after flush", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule